// File: doc/BRIEF.md
# Latched-Divisor Baud Tick Generator

This block turns a free-running peripheral clock into two clock enables for a serial port. A 16-bit divisor, loaded by software through a small byte-wide register bus, sets how many clock cycles separate successive oversample ticks. A second stage counts oversample ticks and emits one bit-rate tick for every sixteen of them, by default. Both ticks are single-cycle pulses that the shifters of the serial port use as enables.

The two divisor bytes are banked: they are only visible while the access-select input is high. With that input low, the high-byte slot instead reaches a four-bit interrupt-enable register, and the low-byte slot belongs to the receive/transmit data path, which is outside this block. A divisor written as zero is treated as one. A new divisor takes effect at the next reload of the cycle counter. A write restarts neither counter, so no short tick interval is ever produced.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset, the divisor reads back as low byte 0x01 and high byte 0x00, the interrupt-enable bits are all 0, and ticks are spaced as for a divisor of 1.
- R2: With divisor N (N >= 1), `os_tick` is a one-cycle pulse that repeats every N clock cycles. N = 1 keeps it high on every cycle.
- R3: A programmed divisor of 0x0000 yields the same tick spacing as 0x0001, and the register still reads back 0x00.
- R4: `bit_tick` pulses only together with `os_tick`, once for every OVS (default 16) oversample ticks, so it is spaced OVS*N cycles apart.
- R5: While `dlab_sel` is 1, byte offset 0x0 reads and writes divisor bits 7:0, and offset 0x4 reads and writes divisor bits 15:8.
- R6: While `dlab_sel` is 0, offset 0x4 reads and writes the interrupt-enable register (bit 0 receive-data-available together with receive timeout, bit 1 transmit-holding-empty, bit 2 receive line status, bit 3 modem status), and its bits 7:4 read as 0. Writes to offset 0x0 leave the divisor unchanged, and reads of offset 0x0 return 0.
- R7: A divisor write does not disturb the interval in progress. The old spacing finishes, and the new spacing applies from the next reload onward.
- R8: `bus_rdata` shows the register selected by the address of the previous cycle (one cycle of latency). Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dlab_sel | input | 1 | Access select: 1 banks in the divisor bytes |
| bus_addr | input | 3 | Byte offset of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| irq_en | output | 4 | Interrupt-enable bits |
| os_tick | output | 1 | Oversample enable pulse |
| bit_tick | output | 1 | Bit-rate enable pulse |

## Verification
A write is captured at the clock edge that ends its cycle. Read data appears one edge after the address is presented, and the bench samples it at the following falling edge. A tick is high during the whole cycle in which the counter holds its final count, so the bench counts falling edges from one sampled tick to the next. Before it measures a new divisor, the bench lets one tick pass after the write, because the interval that was already running must finish with the old value. Only the run that checks R7 measures that running interval, and it expects the old spacing.

// File: rtl/baud_pkg.sv
package baud_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;
    localparam int DIV_W  = 16;
    localparam int IE_W   = 4;
    localparam int NBYTES = DIV_W / DATA_W;

    localparam logic [ADDR_W-1:0] OFF_DIV_LO = 3'd0;
    localparam logic [ADDR_W-1:0] OFF_DIV_HI = 3'd4;

    localparam logic [DIV_W-1:0] DIV_RESET = 16'h0001;

    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic [IE_W-1:0]   ie;
        logic [DATA_W-1:0] rdata;
    } regs_t;
endpackage

// File: rtl/baud_regbank.sv
module baud_regbank
    import baud_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dlab_sel,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DIV_W-1:0]  div_val,
    output logic [IE_W-1:0]   ie_val
);
    regs_t regs_d, regs_q;

    logic [NBYTES-1:0]       byte_hit;
    logic [DATA_W-1:0]       byte_rd [NBYTES];

    // Byte g of the divisor sits at offset 4*g, visible only when banked in.
    for (genvar g = 0; g < NBYTES; g++) begin : g_byte
        assign byte_hit[g] = dlab_sel && (bus_addr == ADDR_W'(4 * g));
        assign byte_rd[g]  = regs_q.div[g*DATA_W +: DATA_W];
    end

    always_comb begin
        regs_d       = regs_q;
        regs_d.rdata = '0;
        for (int b = 0; b < NBYTES; b++) begin
            if (byte_hit[b]) begin
                regs_d.rdata = byte_rd[b];
                if (bus_we) regs_d.div[b*DATA_W +: DATA_W] = bus_wdata;
            end
        end
        if (!dlab_sel && bus_addr == OFF_DIV_HI) begin
            regs_d.rdata = {{(DATA_W-IE_W){1'b0}}, regs_q.ie};
            if (bus_we) regs_d.ie = bus_wdata[IE_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q.div   <= DIV_RESET;
            regs_q.ie    <= '0;
            regs_q.rdata <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign bus_rdata = regs_q.rdata;
    assign div_val   = regs_q.div;
    assign ie_val    = regs_q.ie;

    // R6
    ie_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && dlab_sel) |=> $stable(ie_val));
    // R6
    div_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !dlab_sel) |=> $stable(div_val));
endmodule

// File: rtl/baud_divider.sv
module baud_divider
    import baud_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_val,
    output logic             os_tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } div_state_t;

    div_state_t st_d, st_q;
    logic [DIV_W-1:0] reload;
    logic             expire;

    assign reload = (div_val == '0) ? DIV_W'(1) : div_val;
    assign expire = (st_q.cnt == DIV_W'(1));

    always_comb begin
        st_d = st_q;
        if (expire) st_d.cnt = reload;
        else        st_d.cnt = st_q.cnt - DIV_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.cnt <= DIV_W'(1);
        else        st_q     <= st_d;
    end

    assign os_tick = expire;

    // R2
    cnt_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt != '0);
    // R7
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !os_tick |=> st_q.cnt == $past(st_q.cnt) - DIV_W'(1));
endmodule

// File: rtl/baud_bitdiv.sv
module baud_bitdiv #(
    parameter int OVS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic os_tick,
    output logic bit_tick
);
    localparam int OVS_W = (OVS > 1) ? $clog2(OVS) : 1;
    localparam logic [OVS_W-1:0] LAST = OVS_W'(OVS - 1);

    typedef struct packed {
        logic [OVS_W-1:0] cnt;
    } bd_state_t;

    bd_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (os_tick) st_d.cnt = (st_q.cnt == LAST) ? '0 : st_q.cnt + OVS_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.cnt <= '0;
        else        st_q     <= st_d;
    end

    assign bit_tick = os_tick && (st_q.cnt == LAST);

    // R4
    bit_needs_os_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> os_tick);
    // R4
    bit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (os_tick && !bit_tick) |=> st_q.cnt == $past(st_q.cnt) + OVS_W'(1));
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
    import baud_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dlab_sel,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [IE_W-1:0]   irq_en,
    output logic              os_tick,
    output logic              bit_tick
);
    logic [DIV_W-1:0] div_val;

    baud_regbank u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .dlab_sel  (dlab_sel),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .div_val   (div_val),
        .ie_val    (irq_en)
    );

    baud_divider u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_val (div_val),
        .os_tick (os_tick)
    );

    baud_bitdiv #(.OVS(OVS)) u_bit (
        .clk      (clk),
        .rst_n    (rst_n),
        .os_tick  (os_tick),
        .bit_tick (bit_tick)
    );
endmodule

// File: tb/baud_tick_gen_tb.sv
module baud_tick_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dlab_sel = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [3:0] irq_en;
    logic       os_tick, bit_tick;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    baud_tick_gen dut_i (
        .clk(clk), .rst_n(rst_n), .dlab_sel(dlab_sel), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_en(irq_en), .os_tick(os_tick), .bit_tick(bit_tick)
    );

    // {divisor, expected oversample spacing}
    localparam logic [31:0] VEC [5] = '{
        {16'h0000, 16'd1}, {16'h0001, 16'd1}, {16'h0002, 16'd2},
        {16'h0005, 16'd5}, {16'h1234, 16'h1234}
    };

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input bit sel, input logic [2:0] a, input logic [7:0] d);
        dlab_sel = sel; bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input bit sel, input logic [2:0] a, output int d);
        dlab_sel = sel; bus_addr = a; bus_we = 1'b0;
        @(negedge clk);
        d = int'(bus_rdata);
    endtask

    task automatic wait_tick(input bit which);
        int g = 0;
        do begin @(negedge clk); g++; end
        while (!(which ? bit_tick : os_tick) && g < 150000);
    endtask

    task automatic interval(input bit which, output int n);
        wait_tick(which);
        n = 0;
        do begin @(negedge clk); n++; end
        while (!(which ? bit_tick : os_tick) && n < 150000);
    endtask

    initial begin
        #(4 * 190000);
        bad++; total++;
        $display("FAIL watchdog expired before all R checks finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int v, n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        chk("R1 irq_en reset", int'(irq_en), 0);
        rd(1'b1, 3'd0, v); chk("R1 div lo reset", v, 8'h01);
        rd(1'b1, 3'd4, v); chk("R1 div hi reset", v, 8'h00);
        rd(1'b0, 3'd4, v); chk("R1 ie reset read", v, 0);
        interval(1'b0, n); chk("R1 reset spacing", n, 1);

        // R2 R3 R5 table of divisors
        for (int i = 0; i < 5; i++) begin
            logic [15:0] dv, ex;
            {dv, ex} = VEC[i];
            wr(1'b1, 3'd0, dv[7:0]);
            wr(1'b1, 3'd4, dv[15:8]);
            rd(1'b1, 3'd0, v); chk("R5 div lo readback", v, int'(dv[7:0]));
            rd(1'b1, 3'd4, v); chk("R5 div hi readback", v, int'(dv[15:8]));
            wait_tick(1'b0);
            interval(1'b0, n);
            chk(dv == 0 ? "R3 zero divisor spacing" : "R2 os spacing", n, int'(ex));
            if (ex <= 5) begin
                interval(1'b1, n); chk("R4 bit spacing", n, 16 * int'(ex));
                chk("R4 bit with os", int'(os_tick), 1);
            end
        end

        // R6 banking
        wr(1'b1, 3'd0, 8'h02); wr(1'b1, 3'd4, 8'h00);
        wr(1'b0, 3'd4, 8'hFF);
        chk("R6 ie written", int'(irq_en), 4'hF);
        rd(1'b0, 3'd4, v); chk("R6 ie read upper zero", v, 8'h0F);
        rd(1'b1, 3'd4, v); chk("R6 div hi untouched", v, 8'h00);
        wr(1'b0, 3'd0, 8'h77);
        rd(1'b1, 3'd0, v); chk("R6 div lo untouched", v, 8'h02);
        rd(1'b0, 3'd0, v); chk("R6 data slot reads 0", v, 0);
        wr(1'b1, 3'd4, 8'h00);
        chk("R6 ie kept on div write", int'(irq_en), 4'hF);
        wr(1'b0, 3'd4, 8'h05);
        chk("R6 ie partial", int'(irq_en), 4'h5);

        // R8 latency and unmapped
        rd(1'b1, 3'd2, v); chk("R8 unmapped read", v, 0);
        dlab_sel = 1'b1; bus_addr = 3'd0;
        @(negedge clk); bus_addr = 3'd6;
        chk("R8 one-cycle latency", int'(bus_rdata), 8'h02);
        @(negedge clk);
        chk("R8 next address zero", int'(bus_rdata), 0);

        // R7 no runt on divisor change
        wr(1'b1, 3'd0, 8'd100);
        wait_tick(1'b0); wait_tick(1'b0);
        n = 0;
        repeat (10) begin @(negedge clk); n++; end
        wr(1'b1, 3'd0, 8'd3); n++;
        while (!os_tick) begin @(negedge clk); n++; end
        chk("R7 old interval completes", n, 100);
        interval(1'b0, n); chk("R7 new interval", n, 3);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule